// File: doc/BRIEF.md
# Privileged Control Register File with Nested Trap Stack

This block holds the privileged control and status state of a processor core that supports nested traps. One addressed access port reads and writes every location. Five per-level trap registers (saved PC, saved next-PC, saved state, trap type and saved hyper-state) form a stack. The current trap level picks the stack entry implicitly, so software always sees the entry of the trap being handled. Around the stack sit the single registers for processor state, trap level, interrupt level, window pointer, global level, hyper-state, the two trap base addresses, the MMU contexts and partition, load/store unit control, FP register state, strand status, eight scratch locations and one read-only word that packs MMU-relevant fields from several of them.

Several registers filter what is written. Processor state keeps only its defined bits. The trap base drops its low offset bits. The window pointer and the trap level saturate at their maximums. Each trap-level write also re-evaluates a registered interrupt line that signals a drop to trap level zero while the hyper-state allows it. Reads are combinational from the current state. Writes land on the rising clock edge.

Top module: `priv_ctl_regfile`

## Requirements
- R1: The 5-bit address map is: 0 saved PC, 1 saved next-PC, 2 saved state, 3 trap type, 4 saved hyper-state, 5 processor state, 6 trap level, 7 interrupt level, 8 window pointer, 9 global level, 10 hyper-state, 11 trap base, 12 hyper trap base, 13 primary context, 14 secondary context, 15 partition, 16 load/store control, 17 FP register state, 18 strand status, 19 MMU info (read-only), 20 to 27 scratch 0 to 7. A write with acc_en and acc_we takes effect at the rising edge, and acc_rdata shows the current contents of the addressed location combinationally.
- R2: Synchronous active-high reset sets hyper-state to 0x800 and strand status to 0x50000. It clears every other register, every stack entry, tlz_irq and acc_err.
- R3: The five trap-stack locations access entry TL-1. Each level keeps its own values.
- R4: With TL equal to 0, trap-stack reads return 0 and trap-stack writes change no entry.
- R5: A processor-state write stores the value ANDed with 0x13DE, which keeps bits 12, 9:6 and 4:1.
- R6: A trap-base write stores the value with bits 14:0 cleared.
- R7: A window-pointer write of NWIN or more stores NWIN-1. Smaller values are stored unchanged.
- R8: A trap-level write above MAX_TL stores MAX_TL.
- R9: At each trap-level write edge, tlz_irq becomes 1 when hyper-state bit 0 is set, the stored new level is 0 and hyper-state bit 2 is clear, and becomes 0 otherwise. tlz_irq keeps its value when no trap-level write occurs.
- R10: The MMU info word is laid out as follows: bit 0 is hyper-state[2]; bit 1 is hyper-state[5]; bits 3:2 are processor state[3:2]; bits 5:4 are load/store control[3:2]; bits 15:8 are partition[7:0]; bits 18:16 are TL[2:0]; bits 47:32 are primary context[15:0]; bits 63:48 are secondary context[15:0]. All other bits are 0.
- R11: An FP register state read returns the stored value with bits 1:0 forced to 1.
- R12: The eight scratch locations are independent 64-bit read/write storage.
- R13: Two kinds of access set the sticky acc_err flag: any access to addresses 28 to 31, and a write to the MMU info address. Only reset clears acc_err. Reads of unmapped addresses return 0, and such writes change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_en | input | 1 | Access valid this cycle |
| acc_we | input | 1 | 1 = write, 0 = read |
| acc_addr | input | 5 | Register address |
| acc_wdata | input | 64 | Write data |
| acc_rdata | output | 64 | Read data of the addressed location |
| tlz_irq | output | 1 | Registered trap-level-zero interrupt |
| acc_err | output | 1 | Sticky bad-access flag |

## Verification
A trap-level write does two things at one edge: it moves the trap-stack index and it re-evaluates tlz_irq. Both results must be consistent in the cycle that follows. The bench fills several stack levels and sets the hyper-state enable with a write placed immediately before the trap-level write, with no idle cycle between them. It then checks in the next cycle that tlz_irq reflects the just-written hyper-state and that trap-stack reads already return zero for level 0. A later write that sets the privileged hyper-state bit must leave tlz_irq unchanged until the next trap-level write clears it.

// File: rtl/priv_ctl_pkg.sv
package priv_ctl_pkg;

    localparam int ADDR_W     = 5;
    localparam int XLEN       = 64;
    localparam int N_TRAP_FLD = 5;
    localparam int N_SCRATCH  = 8;

    typedef enum logic [ADDR_W-1:0] {
        A_TPC     = 5'd0,
        A_TNPC    = 5'd1,
        A_TSTATE  = 5'd2,
        A_TT      = 5'd3,
        A_HTSTATE = 5'd4,
        A_PSTATE  = 5'd5,
        A_TL      = 5'd6,
        A_PIL     = 5'd7,
        A_CWP     = 5'd8,
        A_GL      = 5'd9,
        A_HPSTATE = 5'd10,
        A_TBA     = 5'd11,
        A_HTBA    = 5'd12,
        A_PCTX    = 5'd13,
        A_SCTX    = 5'd14,
        A_PART    = 5'd15,
        A_LSU     = 5'd16,
        A_FPRS    = 5'd17,
        A_STRAND  = 5'd18,
        A_MMUINFO = 5'd19,
        A_SCR0    = 5'd20
    } reg_addr_e;

    localparam logic [XLEN-1:0] PSTATE_KEEP = 64'h0000_0000_0000_13DE;
    localparam logic [XLEN-1:0] TBA_LOW     = 64'h0000_0000_0000_7FFF;
    localparam logic [XLEN-1:0] HPSTATE_RST = 64'h0000_0000_0000_0800;
    localparam logic [XLEN-1:0] STRAND_RST  = 64'h0000_0000_0005_0000;
    localparam int HP_TLZ_BIT   = 0;
    localparam int HP_HPRIV_BIT = 2;

    typedef struct packed {
        logic [XLEN-1:0] pstate;
        logic [XLEN-1:0] pil;
        logic [XLEN-1:0] cwp;
        logic [XLEN-1:0] gl;
        logic [XLEN-1:0] hpstate;
        logic [XLEN-1:0] tba;
        logic [XLEN-1:0] htba;
        logic [XLEN-1:0] pctx;
        logic [XLEN-1:0] sctx;
        logic [XLEN-1:0] part;
        logic [XLEN-1:0] lsu;
        logic [XLEN-1:0] fprs;
        logic [XLEN-1:0] strand;
    } ctl_regs_t;

    typedef struct packed {
        logic       valid;
        logic       ro;
        logic       trap;
        logic [2:0] fld;
        logic       scr;
        logic [2:0] scr_idx;
    } dec_t;

    function automatic dec_t decode(logic [ADDR_W-1:0] a);
        dec_t d;
        logic [ADDR_W-1:0] off;
        d   = '0;
        off = a - A_SCR0;
        if (a <= A_HTSTATE) begin
            d.valid = 1'b1;
            d.trap  = 1'b1;
            d.fld   = a[2:0];
        end else if (a >= A_SCR0 && off < ADDR_W'(N_SCRATCH)) begin
            d.valid   = 1'b1;
            d.scr     = 1'b1;
            d.scr_idx = off[2:0];
        end else if (a <= A_MMUINFO) begin
            d.valid = 1'b1;
            d.ro    = (a == A_MMUINFO);
        end
        return d;
    endfunction

    function automatic logic [XLEN-1:0] pack_mmu(ctl_regs_t r, logic [2:0] tl3);
        logic [XLEN-1:0] w;
        w          = '0;
        w[0]       = r.hpstate[2];
        w[1]       = r.hpstate[5];
        w[3:2]     = r.pstate[3:2];
        w[5:4]     = r.lsu[3:2];
        w[15:8]    = r.part[7:0];
        w[18:16]   = tl3;
        w[47:32]   = r.pctx[15:0];
        w[63:48]   = r.sctx[15:0];
        return w;
    endfunction

endpackage

// File: rtl/priv_trap_stack.sv
module priv_trap_stack
    import priv_ctl_pkg::*;
#(
    parameter int MAX_TL = 6,
    parameter int TL_W   = 3
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [TL_W-1:0] tl,
    input  logic            we,
    input  logic [2:0]      fld,
    input  logic [XLEN-1:0] wdata,
    output logic [XLEN-1:0] rdata
);

    logic [MAX_TL-1:0][N_TRAP_FLD-1:0][XLEN-1:0] stk;

    for (genvar e = 0; e < MAX_TL; e++) begin : g_ent
        for (genvar f = 0; f < N_TRAP_FLD; f++) begin : g_fld
            logic [XLEN-1:0] cell_q;
            always_ff @(posedge clk) begin
                if (rst)
                    cell_q <= '0;
                else if (we && tl == TL_W'(e + 1) && fld == 3'(f))
                    cell_q <= wdata;
            end
            assign stk[e][f] = cell_q;
        end
    end

    always_comb begin
        rdata = '0;
        for (int e = 0; e < MAX_TL; e++)
            for (int f = 0; f < N_TRAP_FLD; f++)
                if (tl == TL_W'(e + 1) && fld == 3'(f))
                    rdata = stk[e][f];
    end

    // R4: at trap level zero no stack entry may move
    a_r4_tl0_frozen: assert property (@(posedge clk) disable iff (rst)
        (tl == '0) |=> $stable(stk));

endmodule

// File: rtl/priv_scratch.sv
module priv_scratch
    import priv_ctl_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            we,
    input  logic [2:0]      idx,
    input  logic [XLEN-1:0] wdata,
    output logic [XLEN-1:0] rdata
);

    logic [N_SCRATCH-1:0][XLEN-1:0] mem;

    for (genvar i = 0; i < N_SCRATCH; i++) begin : g_scr
        logic [XLEN-1:0] word_q;
        always_ff @(posedge clk) begin
            if (rst)
                word_q <= '0;
            else if (we && idx == 3'(i))
                word_q <= wdata;
        end
        assign mem[i] = word_q;
    end

    assign rdata = mem[idx];

    // R12: scratch contents move only on a scratch write
    a_r12_scratch_hold: assert property (@(posedge clk) disable iff (rst)
        !we |=> $stable(mem));

endmodule

// File: rtl/priv_ctl_regfile.sv
module priv_ctl_regfile
    import priv_ctl_pkg::*;
#(
    parameter int MAX_TL = 6,
    parameter int NWIN   = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              acc_en,
    input  logic              acc_we,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic [XLEN-1:0]   acc_wdata,
    output logic [XLEN-1:0]   acc_rdata,
    output logic              tlz_irq,
    output logic              acc_err
);

    localparam int TL_W = $clog2(MAX_TL + 1);

    ctl_regs_t       ctl_q;
    logic [TL_W-1:0] tl_q;
    logic [TL_W-1:0] tl_new;
    logic [XLEN-1:0] cwp_new;
    logic [XLEN-1:0] trap_rd;
    logic [XLEN-1:0] scr_rd;
    dec_t            dec;
    logic            wr_ok;
    logic            tl_wr;

    assign dec    = decode(acc_addr);
    assign wr_ok  = acc_en && acc_we && dec.valid && !dec.ro;
    assign tl_wr  = wr_ok && (acc_addr == A_TL);
    assign tl_new = (acc_wdata > XLEN'(MAX_TL)) ? TL_W'(MAX_TL) : acc_wdata[TL_W-1:0];
    assign cwp_new = (acc_wdata >= XLEN'(NWIN)) ? XLEN'(NWIN - 1) : acc_wdata;

    priv_trap_stack #(.MAX_TL(MAX_TL), .TL_W(TL_W)) u_stack (
        .clk   (clk),
        .rst   (rst),
        .tl    (tl_q),
        .we    (wr_ok && dec.trap),
        .fld   (dec.fld),
        .wdata (acc_wdata),
        .rdata (trap_rd)
    );

    priv_scratch u_scratch (
        .clk   (clk),
        .rst   (rst),
        .we    (wr_ok && dec.scr),
        .idx   (dec.scr_idx),
        .wdata (acc_wdata),
        .rdata (scr_rd)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q         <= '0;
            ctl_q.hpstate <= HPSTATE_RST;
            ctl_q.strand  <= STRAND_RST;
            tl_q          <= '0;
            tlz_irq       <= 1'b0;
            acc_err       <= 1'b0;
        end else if (acc_en) begin
            if (!dec.valid || (acc_we && dec.ro))
                acc_err <= 1'b1;
            if (wr_ok) begin
                case (acc_addr)
                    A_PSTATE:  ctl_q.pstate  <= acc_wdata & PSTATE_KEEP;
                    A_TL: begin
                        tl_q    <= tl_new;
                        tlz_irq <= ctl_q.hpstate[HP_TLZ_BIT] && (tl_new == '0)
                                   && !ctl_q.hpstate[HP_HPRIV_BIT];
                    end
                    A_PIL:     ctl_q.pil     <= acc_wdata;
                    A_CWP:     ctl_q.cwp     <= cwp_new;
                    A_GL:      ctl_q.gl      <= acc_wdata;
                    A_HPSTATE: ctl_q.hpstate <= acc_wdata;
                    A_TBA:     ctl_q.tba     <= acc_wdata & ~TBA_LOW;
                    A_HTBA:    ctl_q.htba    <= acc_wdata;
                    A_PCTX:    ctl_q.pctx    <= acc_wdata;
                    A_SCTX:    ctl_q.sctx    <= acc_wdata;
                    A_PART:    ctl_q.part    <= acc_wdata;
                    A_LSU:     ctl_q.lsu     <= acc_wdata;
                    A_FPRS:    ctl_q.fprs    <= acc_wdata;
                    A_STRAND:  ctl_q.strand  <= acc_wdata;
                    default: ;
                endcase
            end
        end
    end

    always_comb begin
        acc_rdata = '0;
        if (dec.trap)
            acc_rdata = trap_rd;
        else if (dec.scr)
            acc_rdata = scr_rd;
        else begin
            case (acc_addr)
                A_PSTATE:  acc_rdata = ctl_q.pstate;
                A_TL:      acc_rdata = XLEN'(tl_q);
                A_PIL:     acc_rdata = ctl_q.pil;
                A_CWP:     acc_rdata = ctl_q.cwp;
                A_GL:      acc_rdata = ctl_q.gl;
                A_HPSTATE: acc_rdata = ctl_q.hpstate;
                A_TBA:     acc_rdata = ctl_q.tba;
                A_HTBA:    acc_rdata = ctl_q.htba;
                A_PCTX:    acc_rdata = ctl_q.pctx;
                A_SCTX:    acc_rdata = ctl_q.sctx;
                A_PART:    acc_rdata = ctl_q.part;
                A_LSU:     acc_rdata = ctl_q.lsu;
                A_FPRS:    acc_rdata = ctl_q.fprs | 64'h3;
                A_STRAND:  acc_rdata = ctl_q.strand;
                A_MMUINFO: acc_rdata = pack_mmu(ctl_q, 3'(tl_q));
                default:   acc_rdata = '0;
            endcase
        end
    end

    // R9: the interrupt only changes at a trap-level write
    a_r9_irq_hold: assert property (@(posedge clk) disable iff (rst)
        !tl_wr |=> $stable(tlz_irq));

    // R13: error flag is sticky until reset
    a_r13_err_sticky: assert property (@(posedge clk) disable iff (rst)
        acc_err |=> acc_err);

    // R7: window pointer never leaves its range
    a_r7_cwp_range: assert property (@(posedge clk) disable iff (rst)
        ctl_q.cwp < XLEN'(NWIN));

    // R8: trap level never exceeds its maximum
    a_r8_tl_range: assert property (@(posedge clk) disable iff (rst)
        tl_q <= TL_W'(MAX_TL));

    // R5: processor state holds the filtered value of the last write
    a_r5_pstate_mask: assert property (@(posedge clk) disable iff (rst)
        (wr_ok && acc_addr == A_PSTATE) |=> ctl_q.pstate == ($past(acc_wdata) & PSTATE_KEEP));

endmodule

// File: tb/priv_ctl_regfile_tb.sv
module priv_ctl_regfile_tb;
    import priv_ctl_pkg::*;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              acc_en = 1'b0;
    logic              acc_we = 1'b0;
    logic [ADDR_W-1:0] acc_addr = '0;
    logic [XLEN-1:0]   acc_wdata = '0;
    logic [XLEN-1:0]   acc_rdata;
    logic              tlz_irq;
    logic              acc_err;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    priv_ctl_regfile u_dut (
        .clk(clk), .rst(rst), .acc_en(acc_en), .acc_we(acc_we),
        .acc_addr(acc_addr), .acc_wdata(acc_wdata), .acc_rdata(acc_rdata),
        .tlz_irq(tlz_irq), .acc_err(acc_err)
    );

    task automatic chk(string req, logic [63:0] got, logic [63:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got 0x%016h expected 0x%016h", req, got, exp);
        end
    endtask

    // all tasks start and end on a falling edge
    task automatic wr(logic [4:0] a, logic [63:0] d);
        acc_en = 1'b1; acc_we = 1'b1; acc_addr = a; acc_wdata = d;
        @(negedge clk);
        acc_en = 1'b0; acc_we = 1'b0;
    endtask

    task automatic rd(logic [4:0] a, output logic [63:0] d);
        acc_en = 1'b1; acc_we = 1'b0; acc_addr = a;
        #1 d = acc_rdata;
        @(negedge clk);
        acc_en = 1'b0;
    endtask

    task automatic expect_rd(string req, logic [4:0] a, logic [63:0] exp);
        logic [63:0] v;
        rd(a, v);
        chk(req, v, exp);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic t_reset();
        expect_rd("R2 hpstate", A_HPSTATE, 64'h800);
        expect_rd("R2 strand", A_STRAND, 64'h50000);
        expect_rd("R2 tl", A_TL, 64'h0);
        expect_rd("R2 pstate", A_PSTATE, 64'h0);
        expect_rd("R2 scratch3", 5'(A_SCR0 + 3), 64'h0);
        chk("R2 irq", {63'h0, tlz_irq}, 64'h0);
        chk("R2 err", {63'h0, acc_err}, 64'h0);
    endtask

    task automatic t_trap_stack();
        wr(A_TL, 64'd1);
        wr(A_TPC, 64'h111);
        wr(A_TL, 64'd2);
        wr(A_TPC, 64'h222);
        wr(A_TT, 64'h33);
        wr(A_TL, 64'd6);
        wr(A_HTSTATE, 64'h6666);
        wr(A_TL, 64'd1);
        expect_rd("R3 tpc lvl1", A_TPC, 64'h111);
        expect_rd("R3 tt lvl1", A_TT, 64'h0);
        wr(A_TL, 64'd2);
        expect_rd("R3 tpc lvl2", A_TPC, 64'h222);
        expect_rd("R3 tt lvl2", A_TT, 64'h33);
        wr(A_TL, 64'd6);
        expect_rd("R3 htstate lvl6", A_HTSTATE, 64'h6666);
        expect_rd("R1 tnpc lvl6", A_TNPC, 64'h0);
    endtask

    task automatic t_tl_zero();
        wr(A_TL, 64'd0);
        wr(A_TPC, 64'hDEAD);
        expect_rd("R4 tpc read at tl0", A_TPC, 64'h0);
        wr(A_TL, 64'd1);
        expect_rd("R4 lvl1 untouched", A_TPC, 64'h111);
        wr(A_TL, 64'd6);
        expect_rd("R4 lvl6 tpc untouched", A_TPC, 64'h0);
    endtask

    task automatic t_masks();
        wr(A_PSTATE, 64'hFFFF_FFFF_FFFF_FFFF);
        expect_rd("R5 pstate mask", A_PSTATE, 64'h13DE);
        wr(A_TBA, 64'hFFFF_FFFF_FFFF_FFFF);
        expect_rd("R6 tba low clear", A_TBA, 64'hFFFF_FFFF_FFFF_8000);
        wr(A_HTBA, 64'h1234_5678);
        expect_rd("R1 htba plain", A_HTBA, 64'h1234_5678);
    endtask

    task automatic t_clamps();
        wr(A_CWP, 64'd5);
        expect_rd("R7 cwp in range", A_CWP, 64'd5);
        wr(A_CWP, 64'd8);
        expect_rd("R7 cwp at NWIN", A_CWP, 64'd7);
        wr(A_CWP, 64'd100);
        expect_rd("R7 cwp large", A_CWP, 64'd7);
        wr(A_TL, 64'd9);
        expect_rd("R8 tl clamp", A_TL, 64'd6);
        wr(A_TL, 64'd6);
        expect_rd("R8 tl at max", A_TL, 64'd6);
    endtask

    task automatic t_tlz();
        wr(A_HPSTATE, 64'h1);
        wr(A_TL, 64'd1);
        chk("R9 irq tl1", {63'h0, tlz_irq}, 64'h0);
        wr(A_TL, 64'd0);
        chk("R9 irq tl0 tlz set", {63'h0, tlz_irq}, 64'h1);
        wr(A_HPSTATE, 64'h5);
        chk("R9 irq holds on hpstate write", {63'h0, tlz_irq}, 64'h1);
        wr(A_TL, 64'd0);
        chk("R9 irq hpriv blocks", {63'h0, tlz_irq}, 64'h0);
        wr(A_HPSTATE, 64'h0);
        wr(A_TL, 64'd0);
        chk("R9 irq tlz clear", {63'h0, tlz_irq}, 64'h0);
    endtask

    // level change and interrupt evaluation on the same edge
    task automatic t_same_edge();
        logic [63:0] v;
        wr(A_TL, 64'd3);
        wr(A_TSTATE, 64'hABC);
        wr(A_HPSTATE, 64'h0);
        wr(A_HPSTATE, 64'h1);
        wr(A_TL, 64'd0);
        chk("R9 irq after back-to-back", {63'h0, tlz_irq}, 64'h1);
        rd(A_TSTATE, v);
        chk("R4 stack hidden at tl0", v, 64'h0);
        wr(A_TL, 64'd3);
        chk("R9 irq falls on tl3", {63'h0, tlz_irq}, 64'h0);
        expect_rd("R3 tstate lvl3 kept", A_TSTATE, 64'hABC);
    endtask

    task automatic t_mmu();
        wr(A_HPSTATE, 64'h24);
        wr(A_PSTATE, 64'hC);
        wr(A_LSU, 64'hC);
        wr(A_PART, 64'h1A5);
        wr(A_TL, 64'd5);
        wr(A_PCTX, 64'h1234_ABCD);
        wr(A_SCTX, 64'h5678);
        expect_rd("R10 mmu info", A_MMUINFO, 64'h5678_ABCD_0005_A53F);
        wr(A_HPSTATE, 64'h20);
        expect_rd("R10 mmu info hp5 only", A_MMUINFO, 64'h5678_ABCD_0005_A53E);
    endtask

    task automatic t_fprs();
        wr(A_FPRS, 64'h40);
        expect_rd("R11 fprs forced", A_FPRS, 64'h43);
        wr(A_FPRS, 64'h0);
        expect_rd("R11 fprs zero", A_FPRS, 64'h3);
    endtask

    task automatic t_scratch();
        for (int i = 0; i < 8; i++)
            wr(5'(A_SCR0 + i), 64'h1000 + 64'(i) * 64'h11);
        for (int i = 0; i < 8; i++)
            expect_rd("R12 scratch", 5'(A_SCR0 + i), 64'h1000 + 64'(i) * 64'h11);
    endtask

    task automatic t_errors();
        logic [63:0] v;
        chk("R13 err clear before", {63'h0, acc_err}, 64'h0);
        rd(5'd29, v);
        chk("R13 unmapped read zero", v, 64'h0);
        chk("R13 err set unmapped", {63'h0, acc_err}, 64'h1);
        wr(A_PIL, 64'h9);
        chk("R13 err sticky", {63'h0, acc_err}, 64'h1);
        do_reset();
        chk("R13 err cleared by reset", {63'h0, acc_err}, 64'h0);
        wr(A_PCTX, 64'h77);
        wr(A_MMUINFO, 64'hFFFF_FFFF_FFFF_FFFF);
        chk("R13 err on ro write", {63'h0, acc_err}, 64'h1);
        expect_rd("R13 ro write no effect", A_MMUINFO, 64'h0000_0077_0000_0000);
        wr(5'd30, 64'h5);
        expect_rd("R13 unmapped write no effect", A_PCTX, 64'h77);
    endtask

    task automatic finish_up();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        do_reset();
        t_reset();
        t_trap_stack();
        t_tl_zero();
        t_masks();
        t_clamps();
        t_tlz();
        t_same_edge();
        t_mmu();
        t_fprs();
        t_scratch();
        t_errors();
        finish_up();
    end

    initial begin
        #(4 * 20000);
        checks++;
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_up();
    end

endmodule